// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps a parameterised set of message-signalled interrupt vectors for a device function. Each vector has a 64-bit message address, a 32-bit message data word and a control word. It also keeps a pending bit per vector and the function-level enable and mask-all flags. Software reaches the table and the pending bits through a 32-bit dword-addressed access port. The flags are set through a control-byte write and reported in a 16-bit control word.

The device raises per-vector requests on `irq_req`. A request on a vector that software has not declared in use is thrown away. A request on a masked vector is held as a pending bit. A request on an unmasked vector is queued, and its address/data pair leaves on a valid/ready message port. When a pending vector becomes unmasked, its pending bit clears and its message is sent. This happens through its own control word, or for all vectors at once when the function mask lifts. Several vectors freed together leave in ascending index order.

Top module: `msix_vec_ctrl`

## Requirements
- R1: The table is dword addressed, and dword `4*v+f` belongs to vector v. Field f=0 is the address low half, f=1 the address high half, f=2 the message data, and f=3 the vector control word, whose bit 0 masks the vector. A read returns the last value written, on `acc_rdata` one cycle after the read request.
- R2: With `acc_sel`=1, read dword k returns the pending bit of vector 32k+j in bit j. Writes with `acc_sel`=1 change nothing.
- R3: A `ctl_wr` writes `ctl_wdata` bit 7 to enable and bit 6 to mask-all. `ctl_rdata` shows enable in bit 15, mask-all in bit 14, and NUM_VEC-1 in bits 10:0, with the rest zero. The function mask is asserted when enable is clear or mask-all is set.
- R4: A request on a vector whose use count is zero sends no message and sets no pending bit.
- R5: A request on an in-use vector that is masked (function mask or its own mask bit) sets its pending bit and sends nothing.
- R6: A request on an in-use, unmasked vector sends a message carrying that entry's current address and data.
- R7: When a vector's own mask bit clears while it is pending, its pending bit clears and its message is sent.
- R8: When the function mask lifts, every pending, individually unmasked vector is sent in ascending index order, and its pending bit clears.
- R9: After reset, enable and mask-all are zero, every address and data dword is zero, every control dword reads 1, and all pending bits are zero.
- R10: `use_inc`/`use_dec` move a per-vector use count. A decrement at zero is ignored. A decrement that brings the count to zero clears that vector's pending bit.
- R11: While `msg_valid` is high and `msg_ready` is low, `msg_addr` and `msg_data` hold, and no other message is dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access request on the dword port |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = vector table, 1 = pending array |
| acc_addr | input | ADDR_W | Dword index |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte (bit 7 enable, bit 6 mask-all) |
| ctl_rdata | output | 16 | Control word readback |
| irq_req | input | NUM_VEC | Per-vector interrupt requests |
| use_inc | input | NUM_VEC | Per-vector use count increment |
| use_dec | input | NUM_VEC | Per-vector use count decrement |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
A corrupted pending bit shows on the next pending-array read. It also shows as an extra or a missing message once the vector is unmasked, two cycles after the unmasking write. A stale previous-mask register shows as a lost or a doubled replay when the function mask lifts. It becomes visible in the order of handshakes within a few cycles. A wrong use count shows when a request that should be dropped produces a message, or the reverse. The output stage is checked by stalling `msg_ready` and watching the held address and data.

// File: rtl/msixv_pkg.sv
package msixv_pkg;
   localparam int DW_PER_VEC   = 4;
   localparam int MAX_VEC      = 2048;
   localparam int CTL_EN_BIT   = 7;
   localparam int CTL_MALL_BIT = 6;

   typedef enum logic [1:0] {
      F_ADDR_LO = 2'd0,
      F_ADDR_HI = 2'd1,
      F_DATA    = 2'd2,
      F_VCTL    = 2'd3
   } vfield_e;

   typedef struct packed {
      logic [63:0] addr;
      logic [31:0] data;
   } msg_t;
endpackage

// File: rtl/msixv_table.sv
module msixv_table
   import msixv_pkg::*;
#(
   parameter int NUM_VEC = 8,
   parameter int ADDR_W  = 5,
   parameter int IDX_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [31:0]        wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [31:0]        rd_data,
   output logic [NUM_VEC-1:0] vmask,
   input  logic [IDX_W-1:0]   lk_idx,
   output msg_t               lk_msg
);
   logic [31:0] alo  [NUM_VEC];
   logic [31:0] ahi  [NUM_VEC];
   logic [31:0] mdat [NUM_VEC];
   logic [31:0] vctl [NUM_VEC];

   logic [ADDR_W-1:0] wr_vec, rd_vec;
   vfield_e           wr_fld, rd_fld;

   assign wr_vec = wr_addr >> 2;
   assign rd_vec = rd_addr >> 2;
   assign wr_fld = vfield_e'(wr_addr[1:0]);
   assign rd_fld = vfield_e'(rd_addr[1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int v = 0; v < NUM_VEC; v++) begin
            alo[v]  <= '0;
            ahi[v]  <= '0;
            mdat[v] <= '0;
            vctl[v] <= 32'd1;
         end
      end else if (wr_en) begin
         for (int v = 0; v < NUM_VEC; v++) begin
            if (wr_vec == ADDR_W'(v)) begin
               case (wr_fld)
                  F_ADDR_LO: alo[v]  <= wr_data;
                  F_ADDR_HI: ahi[v]  <= wr_data;
                  F_DATA:    mdat[v] <= wr_data;
                  default:   vctl[v] <= wr_data;
               endcase
            end
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int v = 0; v < NUM_VEC; v++) begin
         if (rd_vec == ADDR_W'(v)) begin
            case (rd_fld)
               F_ADDR_LO: rd_data = alo[v];
               F_ADDR_HI: rd_data = ahi[v];
               F_DATA:    rd_data = mdat[v];
               default:   rd_data = vctl[v];
            endcase
         end
      end
   end

   always_comb begin
      for (int v = 0; v < NUM_VEC; v++) vmask[v] = vctl[v][0];
   end

   always_comb begin
      lk_msg = '0;
      for (int v = 0; v < NUM_VEC; v++) begin
         if (lk_idx == IDX_W'(v)) begin
            lk_msg.addr = {ahi[v], alo[v]};
            lk_msg.data = mdat[v];
         end
      end
   end
endmodule

// File: rtl/msixv_pend.sv
module msixv_pend #(
   parameter int NUM_VEC = 8,
   parameter int USE_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] irq_req,
   input  logic [NUM_VEC-1:0] use_inc,
   input  logic [NUM_VEC-1:0] use_dec,
   input  logic [NUM_VEC-1:0] masked_now,
   output logic [NUM_VEC-1:0] pend,
   output logic [NUM_VEC-1:0] in_use,
   output logic [NUM_VEC-1:0] send_set
);
   logic [NUM_VEC-1:0] masked_q, unmask_ev, last_drop, live_req;

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_use
      logic [USE_W-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt <= '0;
         else if (use_inc[v] && !use_dec[v] && cnt != '1)
            cnt <= cnt + USE_W'(1);
         else if (use_dec[v] && !use_inc[v] && cnt != '0)
            cnt <= cnt - USE_W'(1);
      end
      assign in_use[v]    = (cnt != '0);
      assign last_drop[v] = use_dec[v] & ~use_inc[v] & (cnt == USE_W'(1));
   end

   assign live_req  = irq_req & in_use;
   assign unmask_ev = masked_q & ~masked_now;
   assign send_set  = (live_req & ~masked_now) | (unmask_ev & pend);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         masked_q <= '1;
         pend     <= '0;
      end else begin
         masked_q <= masked_now;
         pend     <= (pend | (live_req & masked_now)) & ~unmask_ev & ~last_drop;
      end
   end
endmodule

// File: rtl/msixv_sender.sv
module msixv_sender
   import msixv_pkg::*;
#(
   parameter int NUM_VEC = 8,
   parameter int IDX_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] send_set,
   output logic [IDX_W-1:0]   lk_idx,
   input  msg_t               lk_msg,
   output logic [NUM_VEC-1:0] grant,
   output logic               msg_valid,
   input  logic               msg_ready,
   output logic [63:0]        msg_addr,
   output logic [31:0]        msg_data
);
   logic [NUM_VEC-1:0] queue;
   logic               take;

   assign take = !msg_valid || msg_ready;

   always_comb begin
      lk_idx = '0;
      for (int v = NUM_VEC - 1; v >= 0; v--) begin
         if (queue[v]) lk_idx = IDX_W'(v);
      end
   end

   always_comb begin
      grant = '0;
      for (int v = 0; v < NUM_VEC; v++) begin
         if (take && (queue != '0) && lk_idx == IDX_W'(v)) grant[v] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         queue     <= '0;
         msg_valid <= 1'b0;
         msg_addr  <= '0;
         msg_data  <= '0;
      end else begin
         queue <= (queue & ~grant) | send_set;
         if (grant != '0) begin
            msg_valid <= 1'b1;
            msg_addr  <= lk_msg.addr;
            msg_data  <= lk_msg.data;
         end else if (msg_ready) begin
            msg_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
   import msixv_pkg::*;
#(
   parameter int NUM_VEC  = 8,
   parameter int USE_W    = 2,
   parameter bit REG_READ = 1'b1,
   parameter int ADDR_W   = $clog2(NUM_VEC * DW_PER_VEC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_en,
   input  logic               acc_we,
   input  logic               acc_sel,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic [31:0]        acc_wdata,
   output logic [31:0]        acc_rdata,
   input  logic               ctl_wr,
   input  logic [7:0]         ctl_wdata,
   output logic [15:0]        ctl_rdata,
   input  logic [NUM_VEC-1:0] irq_req,
   input  logic [NUM_VEC-1:0] use_inc,
   input  logic [NUM_VEC-1:0] use_dec,
   output logic               msg_valid,
   input  logic               msg_ready,
   output logic [63:0]        msg_addr,
   output logic [31:0]        msg_data
);
   localparam int IDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
   localparam int PBA_DW = (NUM_VEC + 31) / 32;

   if (NUM_VEC < 1 || NUM_VEC > MAX_VEC) begin : g_bad_count
      $error("NUM_VEC out of range");
   end
   if (ADDR_W < $clog2(NUM_VEC * DW_PER_VEC)) begin : g_bad_addr
      $error("ADDR_W too narrow for the table");
   end
   if (USE_W < 1) begin : g_bad_use
      $error("USE_W must be at least 1");
   end

   logic               en_q, mall_q, fmask;
   logic [NUM_VEC-1:0] vmask_vec, masked_vec, pend_vec, inuse_vec, send_vec, grant_vec;
   logic [IDX_W-1:0]   lk_idx;
   msg_t               lk_msg;
   logic [31:0]        tbl_rd, pba_rd, rd_mux;
   logic [PBA_DW*32-1:0] pend_pad;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mall_q <= 1'b0;
      end else if (ctl_wr) begin
         en_q   <= ctl_wdata[CTL_EN_BIT];
         mall_q <= ctl_wdata[CTL_MALL_BIT];
      end
   end

   assign fmask      = !en_q || mall_q;
   assign masked_vec = vmask_vec | {NUM_VEC{fmask}};
   assign ctl_rdata  = {en_q, mall_q, 3'b000, 11'(NUM_VEC - 1)};

   msixv_table #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (acc_en && acc_we && !acc_sel),
      .wr_addr (acc_addr),
      .wr_data (acc_wdata),
      .rd_addr (acc_addr),
      .rd_data (tbl_rd),
      .vmask   (vmask_vec),
      .lk_idx  (lk_idx),
      .lk_msg  (lk_msg)
   );

   msixv_pend #(.NUM_VEC(NUM_VEC), .USE_W(USE_W)) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_req    (irq_req),
      .use_inc    (use_inc),
      .use_dec    (use_dec),
      .masked_now (masked_vec),
      .pend       (pend_vec),
      .in_use     (inuse_vec),
      .send_set   (send_vec)
   );

   msixv_sender #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_send (
      .clk       (clk),
      .rst_n     (rst_n),
      .send_set  (send_vec),
      .lk_idx    (lk_idx),
      .lk_msg    (lk_msg),
      .grant     (grant_vec),
      .msg_valid (msg_valid),
      .msg_ready (msg_ready),
      .msg_addr  (msg_addr),
      .msg_data  (msg_data)
   );

   always_comb begin
      pend_pad = '0;
      pend_pad[NUM_VEC-1:0] = pend_vec;
   end

   always_comb begin
      pba_rd = '0;
      for (int k = 0; k < PBA_DW; k++) begin
         if (acc_addr == ADDR_W'(k)) pba_rd = pend_pad[k*32 +: 32];
      end
   end

   assign rd_mux = acc_sel ? pba_rd : tbl_rd;

   if (REG_READ) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            acc_rdata <= '0;
         else if (acc_en && !acc_we)
            acc_rdata <= rd_mux;
      end
   end else begin : g_rd_comb
      assign acc_rdata = rd_mux;
   end
endmodule

// File: rtl/msixv_chk.sv
module msixv_chk #(
   parameter int NUM_VEC = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               msg_valid,
   input logic               msg_ready,
   input logic [63:0]        msg_addr,
   input logic [31:0]        msg_data,
   input logic [NUM_VEC-1:0] pend,
   input logic [NUM_VEC-1:0] in_use,
   input logic [NUM_VEC-1:0] masked_now,
   input logic [NUM_VEC-1:0] grant
);
   AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R11
   AST_NO_GRANT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |-> grant == '0); // R11
   AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R8
   AST_PEND_NEEDS_USE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & ~in_use) == '0); // R10
   AST_PEND_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ~$past(pend)) & ~$past(masked_now)) == '0); // R5
endmodule

bind msix_vec_ctrl msixv_chk #(.NUM_VEC(NUM_VEC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .msg_valid  (msg_valid),
   .msg_ready  (msg_ready),
   .msg_addr   (msg_addr),
   .msg_data   (msg_data),
   .pend       (pend_vec),
   .in_use     (inuse_vec),
   .masked_now (masked_vec),
   .grant      (grant_vec)
);

// File: tb/tb_msix_vec_ctrl.sv
module tb_msix_vec_ctrl;
   localparam int NV = 8;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_en = 1'b0, acc_we = 1'b0, acc_sel = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic [31:0]   acc_wdata = '0, acc_rdata;
   logic          ctl_wr = 1'b0;
   logic [7:0]    ctl_wdata = '0;
   logic [15:0]   ctl_rdata;
   logic [NV-1:0] irq_req = '0, use_inc = '0, use_dec = '0;
   logic          msg_valid, msg_ready = 1'b1;
   logic [63:0]   msg_addr;
   logic [31:0]   msg_data;

   int n_chk = 0, n_bad = 0, n_log = 0;
   bit done = 1'b0;
   logic [63:0] log_addr [64];
   logic [31:0] log_data [64];

   always #10 clk = ~clk;

   msix_vec_ctrl #(.NUM_VEC(NV)) dut (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we), .acc_sel(acc_sel),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .irq_req(irq_req), .use_inc(use_inc), .use_dec(use_dec),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
   );

   always @(posedge clk) begin
      if (rst_n && msg_valid && msg_ready && n_log < 64) begin
         log_addr[n_log] = msg_addr;
         log_data[n_log] = msg_data;
         n_log++;
      end
   end

   function automatic logic [63:0] ex_addr(int v);
      return {32'h0000_00F0 + 32'(v), 32'hA000_0000 + 32'(v * 16)};
   endfunction
   function automatic logic [31:0] ex_data(int v);
      return 32'h0000_1000 + 32'(v * 3);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input bit sel, input int a, input logic [31:0] d);
      @(negedge clk);
      acc_en = 1'b1; acc_we = 1'b1; acc_sel = sel; acc_addr = AW'(a); acc_wdata = d;
      @(negedge clk);
      acc_en = 1'b0; acc_we = 1'b0;
   endtask

   task automatic rd(input bit sel, input int a, output logic [31:0] d);
      @(negedge clk);
      acc_en = 1'b1; acc_we = 1'b0; acc_sel = sel; acc_addr = AW'(a);
      @(negedge clk);
      acc_en = 1'b0;
      d = acc_rdata;
   endtask

   task automatic ctl(input logic [7:0] b);
      @(negedge clk); ctl_wr = 1'b1; ctl_wdata = b;
      @(negedge clk); ctl_wr = 1'b0;
   endtask

   task automatic pulse_irq(input logic [NV-1:0] m);
      @(negedge clk); irq_req = m;
      @(negedge clk); irq_req = '0;
   endtask

   task automatic pulse_use(input logic [NV-1:0] inc, input logic [NV-1:0] dec);
      @(negedge clk); use_inc = inc; use_dec = dec;
      @(negedge clk); use_inc = '0; use_dec = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_msg(input int i, input int v, input string tag);
      chk(n_log > i && log_addr[i] == ex_addr(v), tag, log_addr[i], ex_addr(v));
      chk(n_log > i && log_data[i] == ex_data(v), tag, 64'(log_data[i]), 64'(ex_data(v)));
   endtask

   task automatic chk_pend(input logic [31:0] exp, input string tag);
      logic [31:0] d;
      rd(1'b1, 0, d);
      chk(d == exp, tag, 64'(d), 64'(exp));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      logic [63:0] held;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R9 / R3: reset state
      chk(ctl_rdata == 16'h0007, "R9 R3 ctl reset", 64'(ctl_rdata), 64'h7);
      for (int a = 0; a < NV * 4; a++) begin
         rd(1'b0, a, d);
         chk(d == ((a % 4 == 3) ? 32'd1 : 32'd0), "R9 table reset", 64'(d), (a % 4 == 3) ? 64'd1 : 64'd0);
      end
      chk_pend(32'h0, "R9 pending reset");

      // R1: program and read back
      for (int v = 0; v < NV; v++) begin
         wr(1'b0, v * 4 + 0, ex_addr(v)[31:0]);
         wr(1'b0, v * 4 + 1, ex_addr(v)[63:32]);
         wr(1'b0, v * 4 + 2, ex_data(v));
      end
      for (int v = 0; v < NV; v++) begin
         rd(1'b0, v * 4 + 0, d); chk(d == ex_addr(v)[31:0], "R1 addr lo", 64'(d), 64'(ex_addr(v)[31:0]));
         rd(1'b0, v * 4 + 1, d); chk(d == ex_addr(v)[63:32], "R1 addr hi", 64'(d), 64'(ex_addr(v)[63:32]));
         rd(1'b0, v * 4 + 2, d); chk(d == ex_data(v), "R1 data", 64'(d), 64'(ex_data(v)));
      end

      ctl(8'h80);
      chk(ctl_rdata == 16'h8007, "R3 enable readback", 64'(ctl_rdata), 64'h8007);

      // R4: vector not in use, even unmasked
      wr(1'b0, 2 * 4 + 3, 32'd0);
      pulse_irq(8'h04); idle(6);
      chk(n_log == 0, "R4 unused drop msg", 64'(n_log), 64'd0);
      chk_pend(32'h0, "R4 unused drop pend");
      wr(1'b0, 2 * 4 + 3, 32'd1);

      // R5: masked in-use requests latch
      pulse_use(8'hFF, 8'h00);
      pulse_irq(8'hFF); idle(6);
      chk(n_log == 0, "R5 masked no msg", 64'(n_log), 64'd0);
      chk_pend(32'hFF, "R5 masked pend");

      // R7: unmask vector 5
      wr(1'b0, 5 * 4 + 3, 32'd0); idle(6);
      chk(n_log == 1, "R7 unmask count", 64'(n_log), 64'd1);
      chk_msg(0, 5, "R7 unmask msg");
      chk_pend(32'hDF, "R7 pend cleared");

      // R10: last reference drop clears pending, then drops requests
      pulse_use(8'h00, 8'h08);
      chk_pend(32'hD7, "R10 unuse clears pend");
      pulse_irq(8'h08); idle(4);
      chk_pend(32'hD7, "R10 R4 unused after drop");
      pulse_use(8'h08, 8'h00);

      // R2: pending array ignores writes
      wr(1'b1, 0, 32'h0);
      chk_pend(32'hD7, "R2 write ignored");

      // R8: function mask replay in ascending order, with stall (R11)
      ctl(8'hC0);
      for (int v = 0; v < NV; v++) wr(1'b0, v * 4 + 3, 32'd0);
      idle(6);
      chk(n_log == 1, "R8 R3 mask-all holds", 64'(n_log), 64'd1);
      chk_pend(32'hD7, "R8 pend held");
      @(negedge clk); msg_ready = 1'b0;
      ctl(8'h80);
      idle(2);
      held = msg_addr;
      chk(msg_valid && held == ex_addr(0), "R11 first stalled", held, ex_addr(0));
      for (int i = 0; i < 4; i++) begin
         idle(1);
         chk(msg_valid && msg_addr == held && msg_data == ex_data(0), "R11 hold", msg_addr, held);
      end
      msg_ready = 1'b1;
      idle(15);
      chk(n_log == 7, "R8 replay count", 64'(n_log), 64'd7);
      chk_msg(1, 0, "R8 order 0");
      chk_msg(2, 1, "R8 order 1");
      chk_msg(3, 2, "R8 order 2");
      chk_msg(4, 4, "R8 order 3");
      chk_msg(5, 6, "R8 order 4");
      chk_msg(6, 7, "R8 order 5");
      chk_pend(32'h0, "R8 pend empty");

      // R6: unmasked requests
      pulse_irq(8'h10); idle(6);
      chk_msg(7, 4, "R6 single");
      pulse_irq(8'h42); idle(8);
      chk(n_log == 10, "R6 pair count", 64'(n_log), 64'd10);
      chk_msg(8, 1, "R6 pair first");
      chk_msg(9, 6, "R6 pair second");

      // R3: disable asserts function mask
      ctl(8'h00);
      chk(ctl_rdata == 16'h0007, "R3 disable readback", 64'(ctl_rdata), 64'h7);
      pulse_irq(8'h02); idle(6);
      chk(n_log == 10, "R3 disabled no msg", 64'(n_log), 64'd10);
      chk_pend(32'h02, "R3 disabled pend");
      ctl(8'h80); idle(6);
      chk_msg(10, 1, "R3 enable replay");
      chk_pend(32'h0, "R3 pend after enable");

      // R10: decrement at zero ignored
      pulse_use(8'h00, 8'h08);
      pulse_use(8'h00, 8'h08);
      pulse_irq(8'h08); idle(6);
      chk(n_log == 11, "R10 dec at zero", 64'(n_log), 64'd11);
      pulse_use(8'h08, 8'h00);
      pulse_irq(8'h08); idle(6);
      chk_msg(11, 3, "R10 reuse");

      finish_run();
   end
endmodule